// File: doc/BRIEF.md
# Compare-Match PWM Timer

This block is a set of independent 16-bit timer channels behind a simple single-cycle register bus with 16-bit data. Each channel counts ticks of a prescaled clock, compares its count against four general compare values, can clear itself on one selected match, and drives one output pin. In PWM mode, compare value A sets where the pin changes level inside a period, and compare value B, used as the clear source, sets the period length. A single start register, shared by all channels, runs or freezes each channel.

Software sets up a channel while it is stopped. It loads the count, the compare values, the clock division, the counting edge, the clear source and the pin behaviour, then sets the channel's start bit. A pin can also be held at a fixed level, for 0% or 100% output, by choosing the "no action" pin behaviour. The interrupt-enable and status words are plain storage and generate nothing.

Top module: `pwm_tmr_top`

## Requirements
- R1: After reset, every register reads 0, every counter is 0 and every pin output is 0.
- R2: The start word at byte address 0x00 holds one bit per channel (bit n for channel n) and reads back what was written. The change takes effect from the cycle after the write. While a channel's bit is 0, its counter and pin do not change, except through bus writes.
- R3: Channel n's registers sit at byte address 0x10 + 64*n plus an offset: 0x00 control, 0x04 mode, 0x08 pin control, 0x0C interrupt enable, 0x10 status, 0x14 counter, 0x18/0x1C/0x20/0x24 compare A/B/C/D. Each is 16-bit read/write storage. Any other address reads 0, and a write to it has no effect.
- R4: Control bits 1:0 select the prescaler. A shared 6-bit cycle counter starts at 0 at reset and advances every clock. Code 0 gives a tick every cycle. Codes 1, 2 and 3 give a tick once every 4, 16 or 64 cycles.
- R5: Control bits 4:3 select the tick phase. 0 ticks when the low 2k bits of the cycle counter are all zero. 1 ticks when they equal half the division. 2 and 3 tick at both of those points. Here k is the prescaler code. With division 1, every cycle ticks.
- R6: Control bits 7:5 select the clear source: 1 = A match, 2 = B match, 5 = C match, 6 = D match, any other code = never (the count wraps from 0xFFFF to 0). A match means the counter equals the compare value on a tick. On a clearing tick the counter loads 0, so a period is compare value + 1 ticks. On other ticks it adds 1.
- R7: Mode bits 2:0 equal to 2 select PWM mode. Any other value selects normal mode. Mode bits 6:4 are stored and read back but change nothing.
- R8: Pin-control bit 2 is the initial level, and bits 1:0 the A-match action (0 none, 1 drive 0, 2 drive 1, 3 toggle). Writing the pin-control word sets the pin to the initial level in the next cycle. This write takes priority over any match in that cycle.
- R9: In normal mode, an A-match tick applies the action to the pin.
- R10: In PWM mode, an A-match tick applies the action, and a B-match tick returns the pin to the initial level. When both match on the same tick, the B match wins.
- R11: With action 0, the pin stays at the initial level in either mode while the counter runs.
- R12: A counter write loads the value when the channel is stopped. While the channel runs, the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W (10) | Byte address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pwm_out | output | NCH (4) | Registered pin output per channel |

## Verification
The assertions take two things for granted. First, a channel's counter and pin move only through a tick of a running channel or through a bus write. Second, a write cycle is the only cycle in which an enabled channel's counter may deviate from +1, 0 or hold. The stimulus reconfigures a channel only with a clear source set and compare values above the live count, so no count has to run through the 16-bit wrap. It always loads a counter while the channel is stopped before it starts that channel. Each write lasts exactly one cycle, followed by an idle cycle, so reads and the per-clock pin comparison never overlap a write in flight.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    localparam int DATA_W = 16;
    localparam int SLOT_W = 4;
    localparam int NSLOT  = 10;

    // register slot index = (offset inside the channel window) / 4
    typedef enum logic [SLOT_W-1:0] {
        SL_CTRL = 4'd0,
        SL_MODE = 4'd1,
        SL_PCTL = 4'd2,
        SL_IEN  = 4'd3,
        SL_STAT = 4'd4,
        SL_CNT  = 4'd5,
        SL_CMPA = 4'd6,
        SL_CMPB = 4'd7,
        SL_CMPC = 4'd8,
        SL_CMPD = 4'd9
    } slot_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } pin_act_e;

    typedef enum logic [1:0] {
        PH_RISE     = 2'd0,
        PH_FALL     = 2'd1,
        PH_BOTH     = 2'd2,
        PH_BOTH_ALT = 2'd3
    } tick_phase_e;

    typedef struct packed {
        logic [2:0]  clr_sel;
        tick_phase_e phase;
        logic [1:0]  div_sel;
        logic        pwm_mode;
        logic        init_lvl;
        pin_act_e    act;
    } ch_cfg_t;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
    } cmp_hit_t;

    function automatic logic clear_hit(input logic [2:0] sel, input cmp_hit_t h);
        case (sel)
            3'd1:    return h.a;
            3'd2:    return h.b;
            3'd5:    return h.c;
            3'd6:    return h.d;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic pin_next(input ch_cfg_t c, input logic cur, input cmp_hit_t h);
        if (c.act == ACT_NONE)      return c.init_lvl;
        if (c.pwm_mode && h.b)      return c.init_lvl;
        if (!h.a)                   return cur;
        case (c.act)
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            default:  return ~cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_tmr_prescale.sv
module pwm_tmr_prescale #(
    parameter int NDIV = 4,
    parameter int STEP = 2
) (
    input  logic            clk,
    input  logic            rst,
    output logic [NDIV-1:0] rise_tick,
    output logic [NDIV-1:0] fall_tick
);
    localparam int PRE_W = STEP * (NDIV - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + PRE_W'(1);
    end

    generate
        for (genvar d = 0; d < NDIV; d++) begin : g_div
            if (d == 0) begin : g_pass
                assign rise_tick[d] = 1'b1;
                assign fall_tick[d] = 1'b1;
            end else begin : g_cmp
                localparam int LW = STEP * d;
                logic [LW-1:0] ph;
                assign ph           = pre_q[LW-1:0];
                assign rise_tick[d] = (ph == '0);
                assign fall_tick[d] = (ph == LW'(1 << (LW - 1)));
            end
        end
    endgenerate
endmodule

// File: rtl/pwm_tmr_channel.sv
module pwm_tmr_channel
    import pwm_tmr_pkg::*;
#(
    parameter int NDIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] slot,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NDIV-1:0]   rise_tick,
    input  logic [NDIV-1:0]   fall_tick,
    output logic [DATA_W-1:0] reg_rd,
    output logic [DATA_W-1:0] cnt_o,
    output logic              pin_o
);
    logic [DATA_W-1:0] regs_q [NSLOT];
    logic [DATA_W-1:0] cnt_q;
    logic              pin_q;
    ch_cfg_t           cfg;
    cmp_hit_t          hit;
    logic              tick;
    logic              step;

    always_comb begin
        cfg.clr_sel  = regs_q[SL_CTRL][7:5];
        cfg.phase    = tick_phase_e'(regs_q[SL_CTRL][4:3]);
        cfg.div_sel  = regs_q[SL_CTRL][1:0];
        cfg.pwm_mode = (regs_q[SL_MODE][2:0] == 3'd2);
        cfg.init_lvl = regs_q[SL_PCTL][2];
        cfg.act      = pin_act_e'(regs_q[SL_PCTL][1:0]);
    end

    always_comb begin
        case (cfg.phase)
            PH_RISE: tick = rise_tick[cfg.div_sel];
            PH_FALL: tick = fall_tick[cfg.div_sel];
            default: tick = rise_tick[cfg.div_sel] | fall_tick[cfg.div_sel];
        endcase
        hit.a = (cnt_q == regs_q[SL_CMPA]);
        hit.b = (cnt_q == regs_q[SL_CMPB]);
        hit.c = (cnt_q == regs_q[SL_CMPC]);
        hit.d = (cnt_q == regs_q[SL_CMPD]);
        step  = run && tick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++) regs_q[i] <= '0;
            cnt_q <= '0;
            pin_q <= 1'b0;
        end else begin
            if (step) begin
                cnt_q <= clear_hit(cfg.clr_sel, hit) ? '0 : cnt_q + DATA_W'(1);
                pin_q <= pin_next(cfg, pin_q, hit);
            end
            if (wr_en) begin
                if (slot == SL_CNT) begin
                    if (!run) cnt_q <= wdata;
                end else if (slot < SLOT_W'(NSLOT)) begin
                    regs_q[slot] <= wdata;
                end
                if (slot == SL_PCTL) pin_q <= wdata[2];
            end
        end
    end

    assign reg_rd = (slot < SLOT_W'(NSLOT)) ? regs_q[slot] : '0;
    assign cnt_o  = cnt_q;
    assign pin_o  = pin_q;
endmodule

// File: rtl/pwm_tmr_top.sv
module pwm_tmr_top
    import pwm_tmr_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int ADDR_W   = 10,
    parameter int NDIV     = 4,
    parameter int DIV_STEP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    localparam int CH_BASE = 16;
    localparam int SPAN_W  = 6;
    localparam int SEL_W   = ADDR_W - SPAN_W;

    logic [NCH-1:0]             run_q;
    logic [ADDR_W-1:0]          rel_addr;
    logic [SEL_W-1:0]           ch_sel;
    logic [SLOT_W-1:0]          slot;
    logic                       in_ch;
    logic                       reg_ok;
    logic [NCH-1:0]             hit_ch;
    logic [NCH-1:0][DATA_W-1:0] ch_rd;
    logic [NCH-1:0][DATA_W-1:0] ch_cnt;
    logic [NDIV-1:0]            rise_tick;
    logic [NDIV-1:0]            fall_tick;

    assign rel_addr = bus_addr - ADDR_W'(CH_BASE);
    assign in_ch    = (bus_addr >= ADDR_W'(CH_BASE));
    assign ch_sel   = rel_addr[ADDR_W-1:SPAN_W];
    assign slot     = rel_addr[SPAN_W-1:2];
    assign reg_ok   = (rel_addr[1:0] == 2'b00) && (slot < SLOT_W'(NSLOT));

    always_ff @(posedge clk) begin
        if (rst)                           run_q <= '0;
        else if (bus_wr && bus_addr == '0) run_q <= bus_wdata[NCH-1:0];
    end

    pwm_tmr_prescale #(.NDIV(NDIV), .STEP(DIV_STEP)) u_prescale (
        .clk       (clk),
        .rst       (rst),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign hit_ch[i] = in_ch && reg_ok && (ch_sel == SEL_W'(i));
            pwm_tmr_channel #(.NDIV(NDIV)) u_ch (
                .clk       (clk),
                .rst       (rst),
                .run       (run_q[i]),
                .wr_en     (bus_wr && hit_ch[i]),
                .slot      (slot),
                .wdata     (bus_wdata),
                .rise_tick (rise_tick),
                .fall_tick (fall_tick),
                .reg_rd    (ch_rd[i]),
                .cnt_o     (ch_cnt[i]),
                .pin_o     (pwm_out[i])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) bus_rdata = DATA_W'(run_q);
        for (int i = 0; i < NCH; i++) begin
            if (hit_ch[i]) bus_rdata = (slot == SL_CNT) ? ch_cnt[i] : ch_rd[i];
        end
    end
endmodule

// File: rtl/pwm_tmr_checker.sv
module pwm_tmr_checker
    import pwm_tmr_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 10
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       bus_wr,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [NCH-1:0]             start_wdata,
    input logic                       pctl_init,
    input logic [NCH-1:0]             run,
    input logic [NCH-1:0][DATA_W-1:0] cnt,
    input logic [NCH-1:0]             pin
);
    assert_start_load_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == '0) |=> (run == $past(start_wdata)));

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_chk
            localparam logic [ADDR_W-1:0] PCTL_ADDR = ADDR_W'(16 + 64 * i + 8);

            assert_frozen_count_R2: assert property (@(posedge clk) disable iff (rst)
                (!run[i] && !bus_wr) |=> $stable(cnt[i]));

            assert_frozen_pin_R2: assert property (@(posedge clk) disable iff (rst)
                (!run[i] && !bus_wr) |=> $stable(pin[i]));

            assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
                (run[i] && !bus_wr) |=> ((cnt[i] == $past(cnt[i]) + DATA_W'(1))
                                         || (cnt[i] == '0) || $stable(cnt[i])));

            assert_pctl_load_R8: assert property (@(posedge clk) disable iff (rst)
                (bus_wr && bus_addr == PCTL_ADDR) |=> (pin[i] == $past(pctl_init)));
        end
    endgenerate
endmodule

bind pwm_tmr_top pwm_tmr_checker #(.NCH(NCH), .ADDR_W(ADDR_W)) u_pwm_tmr_checker (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .start_wdata (bus_wdata[NCH-1:0]),
    .pctl_init   (bus_wdata[2]),
    .run         (run_q),
    .cnt         (ch_cnt),
    .pin         (pwm_out)
);

// File: tb/pwm_tmr_top_bench.sv
module pwm_tmr_top_bench;
    localparam int NCH    = 4;
    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic [NCH-1:0]    pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int m_run [NCH];
    int m_cnt [NCH];
    int m_pin [NCH];
    int m_reg [NCH][10];
    int m_pre;

    pwm_tmr_top #(.NCH(NCH), .ADDR_W(ADDR_W)) u_pwm_tmr_top (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always #10ns clk = ~clk;

    function automatic int m_read(input int a);
        int ch, off, v;
        if (a == 0) begin
            v = 0;
            for (int i = 0; i < NCH; i++) v += m_run[i] << i;
            return v;
        end
        if (a < 16) return 0;
        ch  = (a - 16) / 64;
        off = (a - 16) % 64;
        if (ch >= NCH || off % 4 != 0 || off / 4 >= 10) return 0;
        if (off / 4 == 5) return m_cnt[ch];
        return m_reg[ch][off / 4];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0;
            for (int c = 0; c < NCH; c++) begin
                m_run[c] = 0; m_cnt[c] = 0; m_pin[c] = 0;
                for (int s = 0; s < 10; s++) m_reg[c][s] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                int ctrl, n, ph, es, cs, act, ini;
                bit tk, ha, hb, hc, hd, clr, pwm;
                if (m_run[c] == 0) continue;
                ctrl = m_reg[c][0];
                n  = 1 << (2 * (ctrl & 3));
                ph = m_pre % n;
                es = (ctrl >> 3) & 3;
                if (n == 1)       tk = 1;
                else if (es == 0) tk = (ph == 0);
                else if (es == 1) tk = (ph == n / 2);
                else              tk = (ph == 0) || (ph == n / 2);
                if (!tk) continue;
                ha = (m_cnt[c] == m_reg[c][6]);
                hb = (m_cnt[c] == m_reg[c][7]);
                hc = (m_cnt[c] == m_reg[c][8]);
                hd = (m_cnt[c] == m_reg[c][9]);
                cs = (ctrl >> 5) & 7;
                clr = (cs == 1 && ha) || (cs == 2 && hb) || (cs == 5 && hc) || (cs == 6 && hd);
                pwm = ((m_reg[c][1] & 7) == 2);
                act = m_reg[c][2] & 3;
                ini = (m_reg[c][2] >> 2) & 1;
                if (act == 0)       m_pin[c] = ini;
                else if (pwm && hb) m_pin[c] = ini;
                else if (ha)        m_pin[c] = (act == 1) ? 0 : (act == 2) ? 1 : 1 - m_pin[c];
                m_cnt[c] = clr ? 0 : (m_cnt[c] + 1) % 65536;
            end
            if (bus_wr) begin
                int a, c, off, s;
                a = int'(bus_addr);
                if (a == 0) begin
                    for (int i = 0; i < NCH; i++) m_run[i] = int'(bus_wdata[i]);
                end else if (a >= 16) begin
                    c = (a - 16) / 64; off = (a - 16) % 64; s = off / 4;
                    if (c < NCH && off % 4 == 0 && s < 10) begin
                        if (s == 5) begin
                            if (m_run[c] == 0) m_cnt[c] = int'(bus_wdata);
                        end else begin
                            m_reg[c][s] = int'(bus_wdata);
                        end
                        if (s == 2) m_pin[c] = int'(bus_wdata[2]);
                    end
                end
            end
            m_pre = (m_pre + 1) % 64;
        end
    end

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // pin against the reference on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int i = 0; i < NCH; i++) check(int'(pwm_out[i]), m_pin[i], "R10 per-clock pin vs model");
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = 16'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        bus_addr = ADDR_W'(a);
        #1ns;
        v = int'(bus_rdata);
    endtask

    task automatic rd_chk(input int a, input int exp, input string tag);
        int v;
        rd(a, v);
        check(v, exp, tag);
        check(v, m_read(a), tag);
    endtask

    task automatic measure(input int ch, output int hi, output int per);
        int g;
        g = 0; hi = 0; per = 0;
        @(negedge clk);
        while (pwm_out[ch] !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
        while (pwm_out[ch] !== 1'b1 && g < 5000) begin @(negedge clk); g++; end
        while (pwm_out[ch] === 1'b1 && g < 5000) begin hi++; per++; @(negedge clk); g++; end
        while (pwm_out[ch] === 1'b0 && g < 5000) begin per++; @(negedge clk); g++; end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int hi, per, v1, v2, bad;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_chk(16'h00, 0, "R1 start word");
        rd_chk(16'h50, 0, "R1 ch1 control");
        rd_chk(16'h64, 0, "R1 ch1 counter");
        check(int'(pwm_out), 0, "R1 pins");

        // R3: storage and unmapped addresses
        wr(16'hB0, 16'h1234);
        wr(16'h5C, 16'hBEEF);
        wr(16'h60, 16'h00A5);
        wr(16'h38, 16'hFFFF);
        rd_chk(16'hB0, 16'h1234, "R3 ch2 compare C");
        rd_chk(16'h5C, 16'hBEEF, "R3 ch1 interrupt enable");
        rd_chk(16'h60, 16'h00A5, "R3 ch1 status");
        rd_chk(16'h38, 0, "R3 unmapped slot");
        rd_chk(16'h02, 0, "R3 unmapped low address");

        // R12: counter load while stopped
        wr(16'h24, 16'h0055);
        rd_chk(16'h24, 16'h0055, "R12 load stopped");

        // R10 / R6: ch1 PWM, A=3, B=9, init 0, action high, division 1
        wr(16'h50, 16'h0040);
        wr(16'h54, 16'h0002);
        wr(16'h68, 3);
        wr(16'h6C, 9);
        wr(16'h58, 16'h0002);
        wr(16'h00, 16'h0002);
        rd_chk(16'h00, 2, "R2 start readback");
        measure(1, hi, per);
        check(hi, 6, "R10 high width");
        check(per, 10, "R6 period B+1");

        // R4: division by 4
        wr(16'h50, 16'h0041);
        measure(1, hi, per);
        check(hi, 24, "R4 high width div4");
        check(per, 40, "R4 period div4");

        // R5: both phases, then falling only
        wr(16'h50, 16'h0051);
        measure(1, hi, per);
        check(hi, 12, "R5 high width both");
        check(per, 20, "R5 period both");
        wr(16'h50, 16'h0049);
        measure(1, hi, per);
        check(per, 40, "R5 period falling");

        // R7: buffer flags stored, no effect
        wr(16'h54, 16'h0072);
        rd_chk(16'h54, 16'h0072, "R7 mode readback");
        wr(16'h50, 16'h0051);
        measure(1, hi, per);
        check(hi, 12, "R7 high width with flags");
        check(per, 20, "R7 period with flags");

        // R9: ch2 normal mode, clear on A=4, toggle
        wr(16'h90, 16'h0020);
        wr(16'hA8, 4);
        wr(16'h98, 16'h0003);
        wr(16'h00, 16'h0006);
        measure(2, hi, per);
        check(hi, 5, "R9 toggle high");
        check(per, 10, "R9 toggle period");

        // R11: ch3 PWM with action none, init 1
        wr(16'hD0, 16'h0040);
        wr(16'hD4, 16'h0002);
        wr(16'hE8, 2);
        wr(16'hEC, 7);
        wr(16'hD8, 16'h0004);
        wr(16'h00, 16'h000E);
        bad = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (pwm_out[3] !== 1'b1) bad++; end
        check(bad, 0, "R11 static high samples");

        // R10: A equal to B, B wins so pin never leaves 0
        wr(16'h24, 0);
        wr(16'h10, 16'h0040);
        wr(16'h14, 16'h0002);
        wr(16'h28, 5);
        wr(16'h2C, 5);
        wr(16'h18, 16'h0002);
        wr(16'h00, 16'h000F);
        bad = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwm_out[0] !== 1'b0) bad++; end
        check(bad, 0, "R10 B priority samples");

        // R12: counter write ignored while running
        wr(16'h24, 16'h7777);
        rd(16'h24, v1);
        check(v1, m_read(16'h24), "R12 running write ignored");
        check(int'(v1 <= 5), 1, "R12 count stays in period");

        // R2: stop all and confirm freeze
        wr(16'h00, 0);
        rd_chk(16'h00, 0, "R2 stop readback");
        rd(16'h64, v1);
        hi = int'(pwm_out[1]);
        wait_cyc(20);
        rd(16'h64, v2);
        check(v2, v1, "R2 frozen counter");
        check(int'(pwm_out[1]), hi, "R2 frozen pin");

        // R8: pin-control write sets initial level
        wr(16'h58, 16'h0004);
        check(int'(pwm_out[1]), 1, "R8 init high");
        wr(16'h58, 16'h0000);
        check(int'(pwm_out[1]), 0, "R8 init low");

        wait_cyc(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2ms;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule